// File: doc/BRIEF.md
# Reprogrammable Byte-Wide Memory Mode Controller

This block models the control logic of a byte-wide nonvolatile memory that fits a classic UV-erasable ROM socket but can be erased electrically. On each clock it samples a chip select, a read strobe, a program-supply flag and an address-pin high-voltage flag, all active as described below. From these it picks one operating mode: read, output off, deselected, byte write, whole-array erase, write lockout or identifier readout. The controller drives an 8-bit read bus with a separate drive-enable, and it updates a small internal storage array.

Writing can only turn 1 bits into 0 bits. The only way back to 1 is a whole-array erase, which sets every byte to 0xFF. Write and erase each start on a high-to-low transition of the chip select. Each one then holds a busy flag for a fixed, parameterised number of cycles. While busy is high, reads are blocked and new starts are ignored. The storage depth is a parameter; address bits above it are not decoded.

Top module: `mtp_flash_ctrl`

## Requirements
- R1: After reset, `dq_en` and `busy` are low and every storage location reads 0xFF.
- R2: If the inputs at a clock edge are `ce_n`=0, `oe_n`=0, `vpp_hi`=0, `a9_hv`=0 and `busy` is low, then after that edge `dq_en`=1 and `dq_out` holds the byte stored at `addr[DEPTH_W-1:0]`.
- R3: A write starts at an edge where `ce_n` is 0 after being 1 at the previous edge, with `oe_n`=1, `vpp_hi`=1, `a9_hv`=0 and `busy` low. The addressed location becomes the bitwise AND of its old value and `din`.
- R4: After any edge at which `ce_n` or `oe_n` is 1, `dq_en` is 0.
- R5: After any edge at which `vpp_hi` is 1, `dq_en` is 0.
- R6: An erase starts under the same start conditions as R3 but with `a9_hv`=1. Every location becomes 0xFF regardless of `addr` and `din`, and `busy` stays high for ERASE_CYC cycles.
- R7: After a write start, `busy` stays high for PROG_CYC cycles. While `busy` is high, reads leave `dq_en` at 0, and write or erase starts are ignored.
- R8: While `ce_n` is 1, toggling `vpp_hi`, `a9_hv`, `addr` and `din` changes no stored byte and does not raise `busy`.
- R9: A read with `a9_hv`=1 returns 0xBF when `addr[0]`=0. When `addr[0]`=1 it returns 0xA3 if VARIANT=0, or 0xC3 if VARIANT=1.
- R10: Holding `ce_n` low does not start another operation. A `ce_n` falling edge while `oe_n`=0 does not write, even with `vpp_hi`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| vpp_hi | input | 1 | Program-supply high-voltage present |
| a9_hv | input | 1 | High voltage present on address pin 9 |
| addr | input | ADDR_W (15) | Byte address |
| din | input | DATA_W (8) | Write data |
| dq_out | output | DATA_W (8) | Read data, valid when `dq_en` is high |
| dq_en | output | 1 | Bus drive enable; low means high impedance |
| busy | output | 1 | Write or erase in progress |

## Verification
A wrong start decode or a wrong edge register shows up as a `busy` pulse at the wrong time or of the wrong length. It is visible on the first cycle after the start edge. A wrong AND, a missed erase or a stray write leaves a wrong byte in storage. That byte appears only at the next read of the affected address, so the bench reads back every touched location after each write, erase and lockout sequence. A bad enable term shows as `dq_en` high one cycle after a disallowed combination, or as a missing identifier byte.

// File: rtl/mtp_flash_ctrl.sv
`timescale 1ns/1ps
module mtp_flash_ctrl #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int DEPTH_W   = 6,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 10,
  parameter bit VARIANT   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_en,
  output logic              busy
);
  localparam int DEPTH   = 1 << DEPTH_W;
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [DATA_W-1:0] MFR_CODE = DATA_W'(8'hBF);
  localparam logic [DATA_W-1:0] DEV_CODE = VARIANT ? DATA_W'(8'hC3) : DATA_W'(8'hA3);

  logic              ce_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] mem [DEPTH];

  wire [DEPTH_W-1:0] idx      = addr[DEPTH_W-1:0];
  wire               unused_a = ^addr[ADDR_W-1:DEPTH_W];
  wire               ce_fall  = ce_q & ~ce_n;
  wire               wr_mode  = ~ce_n & oe_n & vpp_hi & ~busy;
  wire               go_prog  = ce_fall & wr_mode & ~a9_hv;
  wire               go_erase = ce_fall & wr_mode &  a9_hv;
  wire               rd       = ~ce_n & ~oe_n & ~vpp_hi & ~busy;
  wire [DATA_W-1:0]  rd_data  = a9_hv ? (addr[0] ? DEV_CODE : MFR_CODE) : mem[idx];

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q   <= 1'b1;
      cnt    <= '0;
      dq_en  <= 1'b0;
      dq_out <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      ce_q   <= ce_n;
      dq_en  <= rd;
      dq_out <= rd ? rd_data : '0;
      if (go_prog)       cnt <= CNT_W'(PROG_CYC);
      else if (go_erase) cnt <= CNT_W'(ERASE_CYC);
      else if (busy)     cnt <= cnt - 1'b1;
      if (go_erase)
        for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      else if (go_prog)
        mem[idx] <= mem[idx] & din;
    end
  end
endmodule

// File: rtl/mtp_flash_ctrl_chk.sv
`timescale 1ns/1ps
module mtp_flash_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic vpp_hi,
  input logic a9_hv,
  input logic dq_en,
  input logic busy,
  input logic ce_q
);
  assert_hiz_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |=> !dq_en);

  assert_hiz_vpp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_hi |=> !dq_en);

  assert_busy_blocks_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !dq_en);

  assert_prog_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ce_q && !ce_n && oe_n && vpp_hi && !a9_hv) |=> busy);

  assert_erase_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ce_q && !ce_n && oe_n && vpp_hi && a9_hv) |=> busy);

  assert_inhibit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !busy) |=> !busy);

  assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_q && !busy) |=> !busy);
endmodule

bind mtp_flash_ctrl mtp_flash_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
  .a9_hv(a9_hv), .dq_en(dq_en), .busy(busy), .ce_q(ce_q)
);

// File: tb/mtp_flash_ctrl_tb.sv
`timescale 1ns/1ps
module mtp_flash_ctrl_tb;
  localparam int PC = 4;
  localparam int EC = 10;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, vpp_hi = 0, a9_hv = 0;
  logic [14:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dq_out;
  logic dq_en, busy;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { bit en; logic [7:0] d; bit b; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  mtp_flash_ctrl #(.ADDR_W(15), .DATA_W(8), .DEPTH_W(6), .PROG_CYC(PC),
                   .ERASE_CYC(EC), .VARIANT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .a9_hv(a9_hv), .addr(addr), .din(din), .dq_out(dq_out), .dq_en(dq_en),
    .busy(busy));

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (dq_en !== it.en || busy !== it.b || (it.en && dq_out !== it.d)) begin
        errors++;
        $display("FAIL %s: en=%b busy=%b dq=%h expected en=%b busy=%b dq=%h",
                 it.tag, dq_en, busy, dq_out, it.en, it.b, it.d);
      end
    end
  end

  task automatic step(input bit c, input bit o, input bit v, input bit h,
                      input logic [14:0] a, input logic [7:0] d,
                      input bit een, input logic [7:0] ed, input bit eb, input string tag);
    item_t it;
    @(negedge clk);
    ce_n = c; oe_n = o; vpp_hi = v; a9_hv = h; addr = a; din = d;
    it.en = een; it.d = ed; it.b = eb; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rd(input logic [14:0] a, input bit h, input logic [7:0] e, input string tag);
    step(1, 1, 0, 0, a, 8'h00, 0, 8'h00, 0, tag);
    step(0, 0, 0, h, a, 8'h00, 1, e, 0, tag);
  endtask

  task automatic prog(input logic [14:0] a, input logic [7:0] d);
    step(1, 1, 1, 0, a, d, 0, 8'h00, 0, "R3 setup");
    step(0, 1, 1, 0, a, d, 0, 8'h00, 1, "R3 start");
    for (int i = 1; i < PC; i++) step(0, 1, 1, 0, a, d, 0, 8'h00, 1, "R7 busy");
    step(0, 1, 1, 0, a, d, 0, 8'h00, 0, "R7 busy end");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (dq_en !== 1'b0 || busy !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: en=%b busy=%b expected en=0 busy=0", dq_en, busy);
    end
    rd(15'd5, 0, 8'hFF, "R1 erased at reset");
    rd(15'd63, 0, 8'hFF, "R1 erased at reset top");
    prog(15'd5, 8'h5A);
    rd(15'd5, 0, 8'h5A, "R2 read after write");
    prog(15'd5, 8'h0F);
    rd(15'd5, 0, 8'h0A, "R3 and with old data");
    prog(15'd9, 8'hF0);
    rd(15'd9, 0, 8'hF0, "R2 second address");
    rd(15'd5 | 15'h4000, 0, 8'h0A, "R2 upper bits not decoded");
    step(0, 1, 0, 0, 15'd5, 8'h00, 0, 8'h00, 0, "R4 oe high");
    step(1, 0, 0, 0, 15'd5, 8'h00, 0, 8'h00, 0, "R4 ce high");
    step(1, 1, 0, 0, 15'd5, 8'h00, 0, 8'h00, 0, "R4 idle");
    step(0, 0, 1, 0, 15'd5, 8'h00, 0, 8'h00, 0, "R5 vpp blocks read, R10 no write with oe low");
    step(0, 0, 1, 0, 15'd5, 8'h00, 0, 8'h00, 0, "R5 vpp held");
    rd(15'd5, 0, 8'h0A, "R10 byte unchanged");
    rd(15'd0, 1, 8'hBF, "R9 maker code");
    rd(15'd1, 1, 8'hA3, "R9 device code");
    step(1, 1, 1, 1, 15'd5, 8'h00, 0, 8'h00, 0, "R8 inhibit");
    step(1, 0, 1, 0, 15'd9, 8'h00, 0, 8'h00, 0, "R8 inhibit");
    step(1, 1, 1, 1, 15'd9, 8'h11, 0, 8'h00, 0, "R8 inhibit");
    rd(15'd5, 0, 8'h0A, "R8 byte kept");
    rd(15'd9, 0, 8'hF0, "R8 byte kept");
    step(1, 1, 1, 0, 15'd9, 8'h3C, 0, 8'h00, 0, "R7 setup");
    step(0, 1, 1, 0, 15'd9, 8'h3C, 0, 8'h00, 1, "R7 start");
    step(1, 1, 1, 0, 15'd9, 8'h00, 0, 8'h00, 1, "R7 busy");
    step(0, 1, 1, 0, 15'd9, 8'h00, 0, 8'h00, 1, "R7 start ignored");
    step(0, 0, 0, 0, 15'd9, 8'h00, 0, 8'h00, 1, "R7 read blocked");
    step(0, 1, 1, 0, 15'd9, 8'h00, 0, 8'h00, 0, "R7 busy end");
    rd(15'd9, 0, 8'h30, "R7 ignored write left no mark");
    prog(15'd12, 8'h77);
    step(0, 1, 1, 0, 15'd12, 8'h00, 0, 8'h00, 0, "R10 held ce no restart");
    step(0, 1, 1, 0, 15'd12, 8'h00, 0, 8'h00, 0, "R10 held ce no restart");
    rd(15'd12, 0, 8'h77, "R10 byte unchanged");
    step(1, 1, 1, 1, 15'd3, 8'h12, 0, 8'h00, 0, "R6 setup");
    step(0, 1, 1, 1, 15'd3, 8'h12, 0, 8'h00, 1, "R6 start");
    for (int i = 1; i < EC; i++) step(0, 1, 1, 1, 15'd7, 8'h00, 0, 8'h00, 1, "R6 busy");
    step(0, 1, 1, 1, 15'd7, 8'h00, 0, 8'h00, 0, "R6 busy end");
    rd(15'd5, 0, 8'hFF, "R6 erased");
    rd(15'd9, 0, 8'hFF, "R6 erased");
    rd(15'd12, 0, 8'hFF, "R6 erased");
    rd(15'd3, 0, 8'hFF, "R6 erased");
    prog(15'd5, 8'hA5);
    rd(15'd5, 0, 8'hA5, "R3 write after erase");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule